// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that runs a list of word transfers without software help for each word. Software fills three small on-chip RAMs of sixteen entries each: transmit words, per-entry control words and, after a run, received words. It reaches them through one address register and one data register; the address moves on by one after every data access. Software then sets the start pointer and the end pointer, sets the run bit, and leaves the block alone.

The sequencer walks the entries from the start pointer to the end pointer, stepping from 15 back to 0 if needed. For each entry it shifts one word out on MOSI, most significant bit first, and samples MISO at the same time. The received word goes into the receive RAM at the same index. After the last entry the run bit clears by itself and a completion flag is set. The flag can drive the interrupt output. Clock polarity, clock phase, word length and the SCK divisor come from a mode register.

Top module: `queued_spi_master`

## Requirements
- R1: After reset every register reads as zero, the RAMs read as zero, SCK is low and the interrupt output is low.
- R2: The mode register (offset 0x00) and the queue register (offset 0x08) read back the full 16-bit value last written. In the interrupt register (offset 0x0C), bit 8 (enable) reads back as written.
- R3: The RAM address register is at offset 0x10. Its values 0x00-0x0F select transmit entries, 0x10-0x1F select receive entries and 0x20-0x2F select control entries. Each read or write of the data register (offset 0x14) then adds one to the address, and the address register reads back the new value.
- R4: Writing a 1 to bit 15 at offset 0x04 while idle starts a run. The run covers the entries from the start pointer (queue register bits 3:0) to the end pointer (bits 11:8), inclusive, stepping from 15 to 0. Bit 15 reads 1 during the run and returns to 0 by itself after the end entry.
- R5: Each entry shifts out the low L bits of its transmit word, most significant first. L is 8 when bit 14 of the control entry is 0. Otherwise L comes from mode bits 13:10: a value of 0 means 16, values 1 to 7 mean 8, and values 8 to 15 are used as given.
- R6: The L bits sampled from MISO are stored right-justified, with zero upper bits, at the entry's own index in the receive RAM. Receive entries outside the run keep their values.
- R7: Each SCK phase (high or low) lasts D system clocks, where D is mode bits 7:0. While D is 0, SCK stops and the run waits; the run continues once D is nonzero.
- R8: SCK idles at mode bit 9 (polarity). When mode bit 8 (phase) is 0, MISO is sampled on the first edge of each bit. When it is 1, MISO is sampled on the second edge.
- R9: The end of a run sets interrupt register bit 0. Writing 1 to bit 0 clears it. The interrupt output equals bit 0 AND bit 8.
- R10: A write to the queue register during a run reads back at once, but the run still stops at the end pointer that was latched at start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (moves the RAM address when it targets the data register) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong queue pointer makes the wrong transmit word appear on MOSI. That shows in the captured bit stream within one word time, and it also puts a received word into the wrong receive slot, which a read of the receive RAM after the run shows. A wrong edge counter or latched length changes the number of sampling edges per entry, so the total bit count of a run differs from the sum of the expected lengths. A wrong edge parity shifts the sampled bits and corrupts the stored receive words. A stuck sequencer leaves the run bit set, and the bench's bounded polling of offset 0x04 reports it.

// File: rtl/qspi_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the queued SPI master: register offsets and
// sequencer states. Assumes a byte-addressed 16-bit register bus.
package qspi_pkg;
    localparam logic [4:0] OFS_MODE = 5'h00;
    localparam logic [4:0] OFS_RUN  = 5'h04;
    localparam logic [4:0] OFS_QUE  = 5'h08;
    localparam logic [4:0] OFS_INT  = 5'h0C;
    localparam logic [4:0] OFS_ADR  = 5'h10;
    localparam logic [4:0] OFS_DAT  = 5'h14;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOAD  = 2'd1,
        SQ_SHIFT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/qspi_ram.sv
`timescale 1ns/1ps
// Small register-file RAM: one synchronous write port and two
// asynchronous read ports. Cleared by reset. Assumes DEPTH is a power of 2.
module qspi_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/qspi_baud.sv
`timescale 1ns/1ps
// SCK phase timer: gives one tick every DIV cycles while run is high.
// A divisor of 0 gives no ticks. Restarts from zero whenever run drops.
module qspi_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (div != '0) && (cnt_q == div - 1'b1);

    // Phase counter: counts cycles inside one SCK phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt_q <= '0;
        else if (tick)       cnt_q <= '0;
        else if (div != '0)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/qspi_shift.sv
`timescale 1ns/1ps
// One-word SPI shift engine. It loads a right-justified word of len bits
// and makes 2*len SCK edges, one per tick. It samples MISO on the edges
// picked by cpha and shifts on the others. done pulses one cycle after
// the last edge, once rx_word holds the final value.
module qspi_shift #(
    parameter int W  = 16,
    localparam int LW = $clog2(W) + 1,
    localparam int EW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  tx_word,
    input  logic [LW-1:0] len,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tick,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic [W-1:0]  rx_word,
    output logic          active,
    output logic          done
);
    logic [W-1:0]  sh_q;
    logic [W-1:0]  rx_q;
    logic [EW-1:0] edge_q;
    logic [EW-1:0] last_edge;
    logic [LW-1:0] len_q;
    logic          sck_t_q;
    logic          sample_edge;

    assign last_edge   = {len_q, 1'b0} - EW'(1);
    assign sample_edge = (edge_q[0] == cpha);
    assign sck         = sck_t_q ^ cpol;
    assign mosi        = sh_q[W-1];
    assign rx_word     = rx_q;

    // Shift engine: load a word, then one SCK edge per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0; rx_q <= '0; edge_q <= '0; len_q <= '0;
            sck_t_q <= 1'b0; active <= 1'b0; done <= 1'b0;
        end else if (load) begin
            sh_q    <= tx_word << (W - int'(len));
            rx_q    <= '0;
            edge_q  <= '0;
            len_q   <= len;
            sck_t_q <= 1'b0;
            active  <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick && active) begin
                sck_t_q <= ~sck_t_q;
                if (sample_edge)          rx_q <= {rx_q[W-2:0], miso};
                else if (edge_q != '0)    sh_q <= {sh_q[W-2:0], 1'b0};
                edge_q <= edge_q + 1'b1;
                if (edge_q == last_edge) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R5
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (edge_q <= last_edge));
    // R7
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || !active) |=> $stable(sck_t_q));
endmodule

// File: rtl/queued_spi_master.sv
`timescale 1ns/1ps
// Queued SPI master. It holds the bus registers, three 16-entry RAMs
// (transmit, receive, control) reached through an auto-incrementing
// address, and a sequencer that runs entries from a start pointer to an
// end pointer. Assumes one-cycle bus strobes and a divisor set before start.
module queued_spi_master #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int AW     = 5,
    localparam int PW    = $clog2(DEPTH),
    localparam int RAW   = PW + 2,
    localparam int LW    = $clog2(DATA_W) + 1,
    localparam int NBANK = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              irq
);
    import qspi_pkg::*;

    logic [DATA_W-1:0] mode_q, que_q;
    logic              run_q, ie_q, flag_q;
    logic [RAW-1:0]    radr_q;
    logic [PW-1:0]     qptr_q, qend_q;
    seq_state_t        state_q;

    logic [1:0]        bank_sel;
    logic [PW-1:0]     sw_idx;
    logic              dat_wr, dat_rd, start, seq_wr, seq_fin;
    logic              tick, sh_active, sh_done;
    logic [DATA_W-1:0] rx_word, ram_rd;
    logic [LW-1:0]     word_len;
    logic [3:0]        len_field;

    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0][PW-1:0]     bank_wa;
    logic [NBANK-1:0][DATA_W-1:0] bank_wd, rd_sw, rd_q;

    assign bank_sel  = radr_q[RAW-1:PW];
    assign sw_idx    = radr_q[PW-1:0];
    assign dat_wr    = bus_wr && (bus_addr == OFS_DAT);
    assign dat_rd    = bus_rd && (bus_addr == OFS_DAT);
    assign start     = bus_wr && (bus_addr == OFS_RUN) && bus_wdata[15]
                       && (state_q == SQ_IDLE);
    assign seq_wr    = (state_q == SQ_SHIFT) && sh_done;
    assign seq_fin   = seq_wr && (qptr_q == qend_q);
    assign len_field = mode_q[13:10];
    assign irq       = flag_q && ie_q;

    wire unused_bits = ^{rd_q[1], rd_q[2][15], rd_q[2][13:0]};

    // RAM banks: 0 transmit, 1 receive (also written by the sequencer), 2 control.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        if (b == 1) begin : g_rx
            assign bank_we[b] = seq_wr || (dat_wr && bank_sel == 2'(b));
            assign bank_wa[b] = seq_wr ? qptr_q : sw_idx;
            assign bank_wd[b] = seq_wr ? rx_word : bus_wdata;
        end else begin : g_sw
            assign bank_we[b] = dat_wr && (bank_sel == 2'(b));
            assign bank_wa[b] = sw_idx;
            assign bank_wd[b] = bus_wdata;
        end
        qspi_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
            .clk(clk), .rst_n(rst_n), .we(bank_we[b]), .waddr(bank_wa[b]),
            .wdata(bank_wd[b]), .raddr_a(sw_idx), .rdata_a(rd_sw[b]),
            .raddr_b(qptr_q), .rdata_b(rd_q[b]));
    end

    // Word length of the current entry from its control word and the mode field.
    always_comb begin
        if (!rd_q[2][14])          word_len = LW'(8);
        else if (len_field == '0)  word_len = LW'(DATA_W);
        else if (len_field < 4'd8) word_len = LW'(8);
        else                       word_len = LW'(len_field);
    end

    // Software view of the RAM selected by the address register.
    always_comb begin
        case (bank_sel)
            2'd0:    ram_rd = rd_sw[0];
            2'd1:    ram_rd = rd_sw[1];
            2'd2:    ram_rd = rd_sw[2];
            default: ram_rd = '0;
        endcase
    end

    // Register read mux.
    always_comb begin
        case (bus_addr)
            OFS_MODE: bus_rdata = mode_q;
            OFS_RUN:  bus_rdata = {run_q, 15'b0};
            OFS_QUE:  bus_rdata = que_q;
            OFS_INT:  bus_rdata = {7'b0, ie_q, 7'b0, flag_q};
            OFS_ADR:  bus_rdata = DATA_W'(radr_q);
            OFS_DAT:  bus_rdata = ram_rd;
            default:  bus_rdata = '0;
        endcase
    end

    // Software registers: mode, queue pointers, interrupt, RAM address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0; que_q <= '0; ie_q <= 1'b0; flag_q <= 1'b0; radr_q <= '0;
        end else begin
            if (bus_wr && bus_addr == OFS_MODE) mode_q <= bus_wdata;
            if (bus_wr && bus_addr == OFS_QUE)  que_q  <= bus_wdata;
            if (bus_wr && bus_addr == OFS_INT)  ie_q   <= bus_wdata[8];
            if (seq_fin)
                flag_q <= 1'b1;
            else if (bus_wr && bus_addr == OFS_INT && bus_wdata[0])
                flag_q <= 1'b0;
            if (bus_wr && bus_addr == OFS_ADR) radr_q <= bus_wdata[RAW-1:0];
            else if (dat_wr || dat_rd)         radr_q <= radr_q + 1'b1;
        end
    end

    // Queue sequencer: latch pointers at start, load and shift each entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE; run_q <= 1'b0; qptr_q <= '0; qend_q <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start) begin
                    qptr_q  <= que_q[PW-1:0];
                    qend_q  <= que_q[8 +: PW];
                    run_q   <= 1'b1;
                    state_q <= SQ_LOAD;
                end
                SQ_LOAD: state_q <= SQ_SHIFT;
                SQ_SHIFT: if (sh_done) begin
                    if (qptr_q == qend_q) begin
                        run_q   <= 1'b0;
                        state_q <= SQ_IDLE;
                    end else begin
                        qptr_q  <= qptr_q + 1'b1;
                        state_q <= SQ_LOAD;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    qspi_baud #(.DIV_W(8)) u_baud (
        .clk(clk), .rst_n(rst_n), .run((state_q == SQ_SHIFT) && sh_active),
        .div(mode_q[7:0]), .tick(tick));

    qspi_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(state_q == SQ_LOAD), .tx_word(rd_q[0]),
        .len(word_len), .cpol(mode_q[9]), .cpha(mode_q[8]), .tick(tick),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .rx_word(rx_word),
        .active(sh_active), .done(sh_done));

    // R8
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE) |-> (spi_sck == mode_q[9]));
    // R4
    run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> flag_q);
    // R4
    load_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_LOAD) |=> (state_q == SQ_SHIFT) && sh_active);
    // R10
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE) |=> (state_q == SQ_IDLE) || $stable(qend_q));
endmodule

// File: tb/queued_spi_master_test.sv
`timescale 1ns/1ps
module queued_spi_master_test;
    localparam logic [4:0] A_MODE = 5'h00, A_RUN = 5'h04, A_QUE = 5'h08,
                           A_INT = 5'h0C, A_ADR = 5'h10, A_DAT = 5'h14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        sck, mosi, miso, irq;

    always #2.5 clk = ~clk;
    assign miso = ~mosi;

    queued_spi_master uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .irq(irq));

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] tx_m [16];
    logic [15:0] cmd_m [16];
    logic        mon_en = 1'b0, cur_cpol = 1'b0, cur_cpha = 1'b0;
    int          mon_cnt = 0, edge_cnt = 0;
    logic        mon_bits [1024];
    realtime     t_e0, t_e1;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    function automatic int elen(logic [15:0] c, logic [3:0] f);
        if (!c[14]) return 8;
        if (f == 0) return 16;
        if (f < 8) return 8;
        return int'(f);
    endfunction

    // SPI monitor: captures MOSI on each sampling edge of the current mode.
    always @(sck) begin
        if (mon_en) begin
            edge_cnt++;
            if (edge_cnt == 1) t_e0 = $realtime;
            if (edge_cnt == 2) t_e1 = $realtime;
            if ((sck !== cur_cpol) != cur_cpha) begin
                if (mon_cnt < 1024) mon_bits[mon_cnt] = mosi;
                mon_cnt++;
            end
        end
    end

    task automatic set_mode(logic cpol, logic cpha, logic [3:0] f, logic [7:0] dv);
        cur_cpol = cpol; cur_cpha = cpha;
        wr(A_MODE, {2'b10, f, cpol, cpha, dv});
    endtask

    task automatic load_rams();
        wr(A_ADR, 16'h0000);
        for (int i = 0; i < 16; i++) wr(A_DAT, tx_m[i]);
        wr(A_ADR, 16'h0020);
        for (int i = 0; i < 16; i++) wr(A_DAT, cmd_m[i]);
        wr(A_ADR, 16'h0010);
        for (int i = 0; i < 16; i++) wr(A_DAT, 16'hBEEF);
    endtask

    task automatic wait_idle();
        logic [15:0] d;
        for (int k = 0; k < 4000; k++) begin
            rd(A_RUN, d);
            if (!d[15]) break;
        end
        mon_en = 1'b0;
    endtask

    task automatic start_run(int sp, int ep);
        wr(A_QUE, {4'b0, 4'(ep), 4'b0, 4'(sp)});
        mon_cnt = 0; edge_cnt = 0; mon_en = 1'b1;
        wr(A_RUN, 16'h8000);
    endtask

    // Compare the captured stream and the receive RAM against the model.
    task automatic check_run(int sp, int ep, logic [3:0] f, string tag);
        int idx = 0, mism = 0, rmis = 0, n;
        logic [15:0] d, exp, msk;
        bit inq [16];
        n = ((ep - sp) & 15) + 1;
        for (int i = 0; i < 16; i++) inq[i] = 0;
        for (int k = 0; k < n; k++) begin
            int i = (sp + k) & 15;
            int L = elen(cmd_m[i], f);
            inq[i] = 1;
            for (int b = L - 1; b >= 0; b--) begin
                if (idx < 1024 && mon_bits[idx] !== tx_m[i][b]) mism++;
                idx++;
            end
        end
        chk("R5", {tag, " bit count"}, mon_cnt, idx);
        chk("R5", {tag, " mosi mismatches"}, mism, 0);
        wr(A_ADR, 16'h0010);
        for (int i = 0; i < 16; i++) begin
            int L = elen(cmd_m[i], f);
            msk = (L == 16) ? 16'hFFFF : 16'((1 << L) - 1);
            exp = inq[i] ? (~tx_m[i] & msk) : 16'hBEEF;
            rd(A_DAT, d);
            if (d !== exp) rmis++;
        end
        chk("R6", {tag, " rx mismatches"}, rmis, 0);
        rd(A_RUN, d);
        chk("R4", {tag, " run bit cleared"}, d, 16'h0000);
        rd(A_INT, d);
        chk("R9", {tag, " flag set"}, d[0], 1'b1);
        wr(A_INT, 16'h0001);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [3:0]  fl [3] = '{4'd0, 4'd5, 4'd12};
        int          run_i = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(A_MODE, d); chk("R1", "mode", d, 0);
        rd(A_RUN, d);  chk("R1", "run", d, 0);
        rd(A_QUE, d);  chk("R1", "queue", d, 0);
        rd(A_INT, d);  chk("R1", "int", d, 0);
        rd(A_DAT, d);  chk("R1", "ram entry 0", d, 0);
        rd(A_ADR, d);  chk("R1", "address after one read", d, 16'h0001);
        chk("R1", "sck", sck, 1'b0);
        chk("R1", "irq", irq, 1'b0);

        // R2 readback
        wr(A_MODE, 16'hB7A5); rd(A_MODE, d); chk("R2", "mode readback", d, 16'hB7A5);
        wr(A_QUE, 16'h5A3C);  rd(A_QUE, d);  chk("R2", "queue readback", d, 16'h5A3C);
        chk("R8", "idle sck follows polarity 1", sck, 1'b1);
        wr(A_MODE, 16'h0000);

        // R3 indirect RAM access with auto-increment
        for (int i = 0; i < 16; i++) begin
            tx_m[i]  = 16'hA5C3 ^ 16'(i * 16'h1357);
            cmd_m[i] = (i % 3 == 1) ? 16'h0000 : 16'h4000;
        end
        load_rams();
        rd(A_ADR, d); chk("R3", "address after 16 writes", d, 16'h0020);
        begin
            int m = 0;
            wr(A_ADR, 16'h0000);
            for (int i = 0; i < 16; i++) begin rd(A_DAT, d); if (d !== tx_m[i]) m++; end
            wr(A_ADR, 16'h0020);
            for (int i = 0; i < 16; i++) begin rd(A_DAT, d); if (d !== cmd_m[i]) m++; end
            chk("R3", "tx/cmd readback mismatches", m, 0);
        end

        // R5 R6 R8: sweep of clock modes and word-length fields
        for (int md = 0; md < 4; md++) begin
            for (int j = 0; j < 3; j++) begin
                int sp = (run_i * 5) & 15;
                int ep = (sp + 3) & 15;
                set_mode(md[1], md[0], fl[j], 8'd2);
                load_rams();
                start_run(sp, ep);
                wait_idle();
                check_run(sp, ep, fl[j], $sformatf("mode%0d len%0d", md, fl[j]));
                run_i++;
            end
        end

        // R4 pointer wrap from 15 to 0
        set_mode(1'b0, 1'b1, 4'd0, 8'd2);
        load_rams();
        start_run(14, 1);
        wait_idle();
        check_run(14, 1, 4'd0, "wrap 14..1");

        // R7 phase length with divisor 3
        set_mode(1'b0, 1'b0, 4'd0, 8'd3);
        load_rams();
        start_run(5, 5);
        wait_idle();
        chk("R7", "half period ps", int'((t_e1 - t_e0) * 1000.0), 15000);
        check_run(5, 5, 4'd0, "div3");

        // R7 divisor 0 stalls, resumes after a nonzero divisor
        set_mode(1'b1, 1'b0, 4'd0, 8'd0);
        load_rams();
        start_run(2, 3);
        repeat (200) @(posedge clk);
        rd(A_RUN, d);
        chk("R7", "divisor 0 run bit held", d[15], 1'b1);
        chk("R7", "divisor 0 no sck edges", edge_cnt, 0);
        set_mode(1'b1, 1'b0, 4'd0, 8'd2);
        wait_idle();
        check_run(2, 3, 4'd0, "div0 resume");

        // R10 queue register write during a run
        set_mode(1'b0, 1'b0, 4'd0, 8'd4);
        load_rams();
        start_run(0, 1);
        wr(A_QUE, 16'h0500);
        rd(A_QUE, d);
        chk("R10", "queue write readback during run", d, 16'h0500);
        wait_idle();
        check_run(0, 1, 4'd0, "R10 latched end");

        // R9 interrupt enable and clear
        set_mode(1'b0, 1'b0, 4'd0, 8'd2);
        wr(A_INT, 16'h0100);
        start_run(7, 7);
        wait_idle();
        #1 chk("R9", "irq with enable", irq, 1'b1);
        rd(A_INT, d); chk("R9", "int reg flag and enable", d, 16'h0101);
        wr(A_INT, 16'h0101);
        rd(A_INT, d); chk("R9", "flag cleared, enable kept", d, 16'h0100);
        #1 chk("R9", "irq low after clear", irq, 1'b0);
        wr(A_INT, 16'h0000);
        start_run(8, 8);
        wait_idle();
        #1 chk("R9", "irq masked", irq, 1'b0);
        rd(A_INT, d); chk("R9", "flag set while masked", d, 16'h0001);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule